// File: doc/BRIEF.md
# WFI Clock-Gating Power Manager

This controller stops the processor core clock after the core retires a wait-for-interrupt instruction and starts it again as soon as an enabled machine-mode interrupt is pending. It runs on the free-running clock and drives the enable pin of an external integrated clock-gating cell. That cell samples its enable while the clock is low, so the gated clock stays free of glitches. The controller also reports whether the core is asleep.

The timer, software and external interrupt lines are watched on the free-running clock. A pulse as short as one cycle that arrives while the core clock is stopped is captured in a held flag. That flag is shown to the core on `irq_held` until the core acknowledges the wake. Wake-up takes one cycle: an enabled interrupt seen at a clock edge raises the gate enable right after that edge.

The state machine has three states:
- `ST_RUN`: the clock runs.
- `ST_DOZE`: the clock is gated.
- `ST_RESUME`: the clock runs again and the controller waits for the core's acknowledge.

It has four transitions:
- `ST_RUN -> ST_DOZE` when a WFI request arrives and nothing enabled is pending.
- `ST_DOZE -> ST_RESUME` when an enabled interrupt is pending.
- `ST_RESUME -> ST_RUN` on `wake_ack`.
- Every other case stays in the current state.

Top module: `wfi_gate_ctrl`

## Requirements
Interrupt bit positions are the same in `irq_lines`, `irq_enable` and `irq_held`: bit 0 is timer, bit 1 is software, bit 2 is external. An interrupt counts as "enabled pending" when its `irq_enable` bit is 1 and either its line or its held flag is 1.

- R1: After reset, `gate_en` is 1, `sleeping` is 0 and `irq_held` is 0.
- R2: A `wfi_req` in `ST_RUN` with no enabled pending interrupt drives `gate_en` to 0 after the next clock edge.
- R3: `sleeping` always equals the inverse of `gate_en`.
- R4: In `ST_DOZE`, an enabled pending interrupt present at a clock edge sets `gate_en` to 1 after that same edge. This is a one-cycle wake latency.
- R5: An interrupt line that is high at an edge sets its `irq_held` bit after that edge. Outside `ST_RUN`, the bit stays set after the line drops, until `wake_ack`.
- R6: A `wfi_req` while an enabled interrupt is pending, on its line or in its held flag, does not gate the clock.
- R7: An interrupt whose enable bit is 0 neither wakes the core nor blocks a WFI. Its pulse is still captured in `irq_held`.
- R8: `wake_ack` in `ST_RESUME` returns the controller to `ST_RUN`. After that edge, each held bit equals that line's value at the edge, so lines that are low are cleared.
- R9: In `ST_RUN`, a held bit clears one cycle after its line goes low.
- R10: A `wfi_req` in `ST_RESUME` is ignored: the clock stays enabled and the held flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | Core retired a wait-for-interrupt instruction |
| irq_lines | input | 3 | Raw interrupt lines: timer, software, external |
| irq_enable | input | 3 | Per-line machine-mode interrupt enables |
| wake_ack | input | 1 | Core acknowledges the wake and releases the held flags |
| gate_en | output | 1 | Enable for the clock-gating cell (1 = clock runs) |
| sleeping | output | 1 | High while the core clock is gated |
| irq_held | output | 3 | Captured interrupt flags, shown to the core |

## Verification
Every result of this block is registered once on the free-running clock. A WFI request, an interrupt edge, or an acknowledge therefore shows up on `gate_en`, `sleeping` and `irq_held` exactly one edge after the cycle in which it was driven. The driver applies each cycle's inputs on the falling edge and queues the outputs expected after the following rising edge. The monitor pops and compares that item 2 ns after that rising edge, so each comparison samples the cycle in which the result is due and no other. The sleep check runs in every compared cycle, and the sequence includes back-to-back WFI and acknowledge cycles as well as disabled-line captures.

// File: rtl/wgc_pkg.sv
package wgc_pkg;

    // Bit positions shared by every interrupt vector of the block
    localparam int IRQ_TIMER    = 0;
    localparam int IRQ_SOFTWARE = 1;
    localparam int IRQ_EXTERNAL = 2;
    localparam int IRQ_COUNT    = 3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOZE   = 2'd1,
        ST_RESUME = 2'd2
    } pm_state_e;

endpackage

// File: rtl/wgc_capture.sv
module wgc_capture #(
    parameter int N_IRQ = wgc_pkg::IRQ_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] line_i,
    input  logic [N_IRQ-1:0] enable_i,
    input  logic             release_i,
    output logic [N_IRQ-1:0] held_o,
    output logic             pend_any_o
);

    logic [N_IRQ-1:0] held_q;
    logic [N_IRQ-1:0] live_pend;

    // One capture flag per line; a high line always wins over the release
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q[g] <= 1'b0;
            end else begin
                held_q[g] <= line_i[g] | (held_q[g] & ~release_i);
            end
        end
        assign live_pend[g] = enable_i[g] & (line_i[g] | held_q[g]);
    end

    assign held_o     = held_q;
    assign pend_any_o = |live_pend;

endmodule

// File: rtl/wgc_fsm.sv
module wgc_fsm
    import wgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_i,
    input  logic pend_any_i,
    input  logic ack_i,
    output logic gate_en_o,
    output logic in_run_o,
    output logic release_o
);

    pm_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_i && !pend_any_i) begin
                    state_d = ST_DOZE;
                end
            end
            ST_DOZE: begin
                if (pend_any_i) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                if (ack_i) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        gate_en_o = 1'b1;
        in_run_o  = 1'b0;
        release_o = ack_i;
        unique case (state_q)
            ST_RUN: begin
                in_run_o  = 1'b1;
                release_o = 1'b1;
            end
            ST_DOZE: begin
                gate_en_o = 1'b0;
            end
            ST_RESUME: begin
                gate_en_o = 1'b1;
            end
            default: begin
                gate_en_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wfi_gate_ctrl.sv
module wfi_gate_ctrl #(
    parameter int N_IRQ = wgc_pkg::IRQ_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic [N_IRQ-1:0] irq_lines,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic             wake_ack,
    output logic             gate_en,
    output logic             sleeping,
    output logic [N_IRQ-1:0] irq_held
);

    logic pend_any;
    logic in_run;
    logic release_flags;

    wgc_capture #(
        .N_IRQ(N_IRQ)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (irq_lines),
        .enable_i  (irq_enable),
        .release_i (release_flags),
        .held_o    (irq_held),
        .pend_any_o(pend_any)
    );

    wgc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi_i     (wfi_req),
        .pend_any_i(pend_any),
        .ack_i     (wake_ack),
        .gate_en_o (gate_en),
        .in_run_o  (in_run),
        .release_o (release_flags)
    );

    assign sleeping = ~gate_en;

    AST_WFI_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && wfi_req && !pend_any) |=> !gate_en); // R2

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && pend_any) |=> gate_en); // R4

    AST_NO_GATE_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && pend_any) |=> gate_en); // R6

    AST_HELD_KEPT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en) |=> ((irq_held & $past(irq_held)) == $past(irq_held))); // R5

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ack && gate_en) |=> (irq_held == $past(irq_lines))); // R8

endmodule

// File: tb/wfi_gate_ctrl_tb.sv
module wfi_gate_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi_req = 1'b0;
    logic [2:0] irq_lines = 3'b000;
    logic [2:0] irq_enable = 3'b111;
    logic       wake_ack = 1'b0;
    logic       gate_en;
    logic       sleeping;
    logic [2:0] irq_held;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       gate;
        logic [2:0] held;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    wfi_gate_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi_req   (wfi_req),
        .irq_lines (irq_lines),
        .irq_enable(irq_enable),
        .wake_ack  (wake_ack),
        .gate_en   (gate_en),
        .sleeping  (sleeping),
        .irq_held  (irq_held)
    );

    // Driver: one call is one cycle of stimulus plus its expected outcome
    task automatic cyc(input logic w, input logic [2:0] irq, input logic [2:0] en,
                       input logic ack, input logic exp_gate, input logic [2:0] exp_held,
                       input string tag);
        exp_t e;
        @(negedge clk);
        wfi_req    = w;
        irq_lines  = irq;
        irq_enable = en;
        wake_ack   = ack;
        e.gate = exp_gate;
        e.held = exp_held;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares the item due after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (gate_en !== e.gate || irq_held !== e.held) begin
                    errors++;
                    $display("FAIL %s gate_en=%0b held=%03b expected gate_en=%0b held=%03b",
                             e.tag, gate_en, irq_held, e.gate, e.held);
                end
                checks++;
                if (sleeping !== ~gate_en) begin
                    errors++;
                    $display("FAIL R3 sleeping=%0b expected %0b", sleeping, ~gate_en);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 3'b000, 3'b111, 0, 1, 3'b000, "R1");
        cyc(1, 3'b000, 3'b111, 0, 0, 3'b000, "R2");
        cyc(0, 3'b000, 3'b111, 0, 0, 3'b000, "R3");
        cyc(0, 3'b001, 3'b111, 0, 1, 3'b001, "R4");
        cyc(0, 3'b000, 3'b111, 0, 1, 3'b001, "R5");
        cyc(1, 3'b000, 3'b111, 0, 1, 3'b001, "R10");
        cyc(0, 3'b000, 3'b111, 1, 1, 3'b000, "R8");
        cyc(1, 3'b000, 3'b111, 0, 0, 3'b000, "R2");
        cyc(0, 3'b010, 3'b101, 0, 0, 3'b010, "R7");
        cyc(0, 3'b000, 3'b101, 0, 0, 3'b010, "R7");
        cyc(0, 3'b100, 3'b101, 0, 1, 3'b110, "R4");
        cyc(0, 3'b000, 3'b111, 1, 1, 3'b000, "R8");
        cyc(0, 3'b100, 3'b111, 1, 1, 3'b100, "R8");
        cyc(0, 3'b000, 3'b111, 0, 1, 3'b000, "R9");
        cyc(1, 3'b001, 3'b111, 0, 1, 3'b001, "R6");
        cyc(1, 3'b000, 3'b111, 0, 1, 3'b000, "R6");
        cyc(1, 3'b001, 3'b000, 0, 0, 3'b001, "R7");
        cyc(0, 3'b000, 3'b111, 0, 1, 3'b001, "R4");
        cyc(0, 3'b000, 3'b111, 1, 1, 3'b000, "R8");
        cyc(0, 3'b000, 3'b111, 0, 1, 3'b000, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule